// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single byte requests into one timed bus cycle on the asynchronous control pins of a raw NAND flash device. A request can be a command byte, an address byte, a data byte to write, or a data byte to read. Every pin edge is placed by one cycle counter per request. The counter is compared against boundaries that are worked out, at the moment the request is accepted, from eleven timing registers. Each latch and enable therefore gets its own setup and hold window around the write strobe, rather than sharing one fixed strobe width.

The timing registers hold counts of clock cycles. Their reset values assume a 200 MHz clock and round each device minimum up to whole 5 ns cycles. Software can rewrite them through a small register write port, so the same logic can serve fast and legacy devices. Read data is captured from the bus at the last clock edge of the read strobe and is handed back with a one-cycle valid pulse. The request side is a valid/ready handshake that accepts only while the block is idle.

Top module: `nand_seq_top`

## Requirements
- R1: After reset, and in every idle cycle, `req_ready` is 1, write and read strobes are high, both latch enables are low and `dq_oe` is 0. Chip enable is high after reset.
- R2: A write request is encoded on `req_op` as 0 = command, 1 = address, 2 = data write. For such a request, let S = max(ce setup, latch setup, data setup, write pulse); the latch setup is 0 for a data write. Counting the first busy cycle as cycle 0, chip enable is low from cycle 0, the write strobe is low in cycles S-wp to S-1, and it is high again in cycle S.
- R3: A command request drives command latch enable high from cycle S-clsu up to cycle S+clh-1, with address latch enable low throughout. An address request does the mirror image with alsu/alh. A data request keeps both latch enables low.
- R4: During every busy cycle of a write request, `dq_oe` is 1 and `dq_out` carries the request byte.
- R5: A write request occupies E = S + max(ceh, latch hold, wh) cycles, and `req_ready` returns to 1 in cycle E. A request is accepted only when `req_valid` and `req_ready` are both 1.
- R6: A read request (`req_op` = 3) holds `dq_oe` at 0 for its whole duration. It drives chip enable low from cycle 0, drives the read strobe low in cycles 1 to rp, and lasts 1+rp+max(reh, ceh) cycles.
- R7: `rd_data` takes the value that `dq_in` had during the last low cycle of the read strobe. `rd_valid` is high for exactly one cycle, cycle 1+rp.
- R8: If `req_valid` is high in the last busy cycle, chip enable stays low into the next request. Otherwise chip enable goes high in the first idle cycle.
- R9: The timing registers are written through `cfg_we`/`cfg_addr`/`cfg_wdata`. The addresses and reset values are: 0 wp=2, 1 wh=2, 2 rp=2, 3 reh=2, 4 cesu=3, 5 ceh=1, 6 clsu=2, 7 clh=1, 8 alsu=2, 9 alh=1, 10 dsu=2. A stored 0 is used as 1.
- R10: A timing register write made during a busy request does not alter that request. It takes effect from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 200 MHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_addr | input | 4 | Timing register index |
| cfg_wdata | input | TW | Timing value in cycles |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_byte | input | DW | Byte for write requests |
| req_ready | output | 1 | High when idle and able to accept |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| dq_out | output | DW | Bus value driven on writes |
| dq_oe | output | 1 | Bus output enable |
| dq_in | input | DW | Bus value from the device |
| rd_data | output | DW | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse with `rd_data` |

## Verification
Two events can meet in one clock cycle: the last hold cycle of a request and the arrival of the next request. Together they decide whether chip enable rises or stays low. The bench provokes this by keeping `req_valid` high, with a new operation, straight after the first request is accepted. It then judges the pins cycle by cycle: chip enable must stay low across the seam, the second latch window must follow, and chip enable may rise only after the second request ends. A timing register write placed inside a busy request is the second overlap. It is judged by measuring the write pulse of that request and of the next one.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_DWR  = 2'd2,
    OP_DRD  = 2'd3
  } nand_op_e;

  localparam int NUM_T  = 11;
  localparam int T_WP   = 0;
  localparam int T_WH   = 1;
  localparam int T_RP   = 2;
  localparam int T_REH  = 3;
  localparam int T_CESU = 4;
  localparam int T_CEH  = 5;
  localparam int T_CLSU = 6;
  localparam int T_CLH  = 7;
  localparam int T_ALSU = 8;
  localparam int T_ALH  = 9;
  localparam int T_DSU  = 10;

  // reset values: device minimums rounded up to 5 ns cycles
  function automatic int t_default(input int idx);
    case (idx)
      T_CESU:                  return 3;
      T_CEH, T_CLH, T_ALH:     return 1;
      default:                 return 2;
    endcase
  endfunction

endpackage

// File: rtl/nand_seq_cfg.sv
`timescale 1ns/1ps
module nand_seq_cfg
  import nand_seq_pkg::*;
#(
  parameter int TW = 4,
  parameter int AW = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [AW-1:0]              cfg_addr,
  input  logic [TW-1:0]              cfg_wdata,
  output logic [NUM_T-1:0][TW-1:0]   t_eff
);

  logic [TW-1:0] t_q [NUM_T];

  for (genvar g = 0; g < NUM_T; g++) begin : g_treg
    always_ff @(posedge clk) begin
      if (rst) begin
        t_q[g] <= TW'(t_default(g));
      end else if (cfg_we && (cfg_addr == AW'(g))) begin
        t_q[g] <= cfg_wdata;
      end
    end
    // zero would collapse a window; treat as one cycle
    assign t_eff[g] = (t_q[g] == '0) ? TW'(1) : t_q[g];
  end

endmodule

// File: rtl/nand_seq_plan.sv
`timescale 1ns/1ps
module nand_seq_plan
  import nand_seq_pkg::*;
#(
  parameter int TW = 4,
  parameter int CW = TW + 2
) (
  input  logic [1:0]                 op,
  input  logic [NUM_T-1:0][TW-1:0]   t_eff,
  output logic [CW-1:0]              we_fall,
  output logic [CW-1:0]              we_rise,
  output logic [CW-1:0]              lat_on,
  output logic [CW-1:0]              lat_off,
  output logic [CW-1:0]              re_rise,
  output logic [CW-1:0]              op_end
);

  function automatic logic [CW-1:0] vmax(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [CW-1:0] wp, wh, rp, reh, cesu, ceh, dsu, lsu, lh, s_pt, tail_w, r_pt;
  nand_op_e      op_e;

  always_comb begin
    op_e = nand_op_e'(op);
    wp   = CW'(t_eff[T_WP]);
    wh   = CW'(t_eff[T_WH]);
    rp   = CW'(t_eff[T_RP]);
    reh  = CW'(t_eff[T_REH]);
    cesu = CW'(t_eff[T_CESU]);
    ceh  = CW'(t_eff[T_CEH]);
    dsu  = CW'(t_eff[T_DSU]);
    case (op_e)
      OP_CMD:  begin lsu = CW'(t_eff[T_CLSU]); lh = CW'(t_eff[T_CLH]); end
      OP_ADDR: begin lsu = CW'(t_eff[T_ALSU]); lh = CW'(t_eff[T_ALH]); end
      default: begin lsu = '0;                 lh = '0;                end
    endcase

    s_pt   = vmax(vmax(cesu, lsu), vmax(dsu, wp));
    tail_w = vmax(vmax(ceh, lh), wh);
    r_pt   = CW'(1) + rp;

    if (op_e == OP_DRD) begin
      we_fall = '0;
      we_rise = '0;
      lat_on  = '0;
      lat_off = '0;
      re_rise = r_pt;
      op_end  = r_pt + vmax(reh, ceh);
    end else begin
      we_fall = s_pt - wp;
      we_rise = s_pt;
      lat_on  = s_pt - lsu;
      lat_off = s_pt + lh;
      re_rise = '0;
      op_end  = s_pt + tail_w;
    end
  end

endmodule

// File: rtl/nand_seq_core.sv
`timescale 1ns/1ps
module nand_seq_core
  import nand_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [DW-1:0] req_byte,
  output logic          req_ready,
  input  logic [CW-1:0] pl_we_fall,
  input  logic [CW-1:0] pl_we_rise,
  input  logic [CW-1:0] pl_lat_on,
  input  logic [CW-1:0] pl_lat_off,
  input  logic [CW-1:0] pl_re_rise,
  input  logic [CW-1:0] pl_end,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic          cap_stb
);

  // sequencing state
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  nand_op_e      op_q, op_d;
  logic [DW-1:0] byte_q, byte_d;
  logic [CW-1:0] wf_q, wr_q, lon_q, loff_q, rr_q, end_q;
  logic [CW-1:0] wf_d, wr_d, lon_d, loff_d, rr_d, end_d;
  logic          accept, last;

  // next pin values
  logic ce_n_d, cle_d, ale_d, we_n_d, re_n_d, oe_d;
  logic [DW-1:0] dq_d;

  assign req_ready = !busy_q;
  assign accept    = !busy_q && req_valid;
  assign last      = busy_q && (cnt_q == end_q - CW'(1));
  assign cap_stb   = busy_q && (op_q == OP_DRD) && (cnt_q == rr_q - CW'(1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    byte_d = byte_q;
    wf_d   = wf_q;
    wr_d   = wr_q;
    lon_d  = lon_q;
    loff_d = loff_q;
    rr_d   = rr_q;
    end_d  = end_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      op_d   = nand_op_e'(req_op);
      byte_d = req_byte;
      wf_d   = pl_we_fall;
      wr_d   = pl_we_rise;
      lon_d  = pl_lat_on;
      loff_d = pl_lat_off;
      rr_d   = pl_re_rise;
      end_d  = pl_end;
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_comb begin
    ce_n_d = 1'b1;
    cle_d  = 1'b0;
    ale_d  = 1'b0;
    we_n_d = 1'b1;
    re_n_d = 1'b1;
    oe_d   = 1'b0;
    dq_d   = '0;
    if (busy_d) begin
      ce_n_d = 1'b0;
      if (op_d == OP_DRD) begin
        re_n_d = !((cnt_d >= CW'(1)) && (cnt_d < rr_d));
      end else begin
        oe_d   = 1'b1;
        dq_d   = byte_d;
        we_n_d = !((cnt_d >= wf_d) && (cnt_d < wr_d));
        cle_d  = (op_d == OP_CMD)  && (cnt_d >= lon_d) && (cnt_d < loff_d);
        ale_d  = (op_d == OP_ADDR) && (cnt_d >= lon_d) && (cnt_d < loff_d);
      end
    end else begin
      // keep the chip selected across back-to-back requests
      ce_n_d = !(last && req_valid);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      op_q      <= OP_CMD;
      byte_q    <= '0;
      wf_q      <= '0;
      wr_q      <= '0;
      lon_q     <= '0;
      loff_q    <= '0;
      rr_q      <= '0;
      end_q     <= CW'(2);
      nand_ce_n <= 1'b1;
      nand_cle  <= 1'b0;
      nand_ale  <= 1'b0;
      nand_we_n <= 1'b1;
      nand_re_n <= 1'b1;
      dq_oe     <= 1'b0;
      dq_out    <= '0;
    end else begin
      busy_q    <= busy_d;
      cnt_q     <= cnt_d;
      op_q      <= op_d;
      byte_q    <= byte_d;
      wf_q      <= wf_d;
      wr_q      <= wr_d;
      lon_q     <= lon_d;
      loff_q    <= loff_d;
      rr_q      <= rr_d;
      end_q     <= end_d;
      nand_ce_n <= ce_n_d;
      nand_cle  <= cle_d;
      nand_ale  <= ale_d;
      nand_we_n <= we_n_d;
      nand_re_n <= re_n_d;
      dq_oe     <= oe_d;
      dq_out    <= dq_d;
    end
  end

endmodule

// File: rtl/nand_seq_rdcap.sv
`timescale 1ns/1ps
module nand_seq_rdcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_stb,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= cap_stb;
      if (cap_stb) begin
        rd_data <= dq_in;
      end
    end
  end

endmodule

// File: rtl/nand_seq_top.sv
`timescale 1ns/1ps
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [DW-1:0] req_byte,
  output logic          req_ready,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  localparam int CW = TW + 2;

  logic [NUM_T-1:0][TW-1:0] t_eff;
  logic [CW-1:0] pl_we_fall, pl_we_rise, pl_lat_on, pl_lat_off, pl_re_rise, pl_end;
  logic          cap_stb;

  nand_seq_cfg #(.TW(TW), .AW(4)) cfg_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .t_eff(t_eff)
  );

  nand_seq_plan #(.TW(TW), .CW(CW)) plan_i (
    .op(req_op), .t_eff(t_eff),
    .we_fall(pl_we_fall), .we_rise(pl_we_rise), .lat_on(pl_lat_on),
    .lat_off(pl_lat_off), .re_rise(pl_re_rise), .op_end(pl_end)
  );

  nand_seq_core #(.DW(DW), .CW(CW)) core_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_byte(req_byte), .req_ready(req_ready),
    .pl_we_fall(pl_we_fall), .pl_we_rise(pl_we_rise), .pl_lat_on(pl_lat_on),
    .pl_lat_off(pl_lat_off), .pl_re_rise(pl_re_rise), .pl_end(pl_end),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .dq_oe(dq_oe),
    .dq_out(dq_out), .cap_stb(cap_stb)
  );

  nand_seq_rdcap #(.DW(DW)) rdcap_i (
    .clk(clk), .rst(rst), .cap_stb(cap_stb), .dq_in(dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: rtl/nand_seq_chk.sv
`timescale 1ns/1ps
module nand_seq_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic dq_oe,
  input logic rd_valid
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !dq_oe));

  assert_we_under_ce_R2: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> !nand_ce_n);

  assert_latch_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  assert_bus_driven_on_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> dq_oe);

  assert_accept_selects_chip_R5: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> (!req_ready && !nand_ce_n));

  assert_bus_released_before_re_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(nand_re_n) |-> (!dq_oe && $past(!dq_oe)));

  assert_no_dual_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

  assert_rdv_single_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  assert_rdv_at_re_rise_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (nand_re_n && $past(!nand_re_n)));

  assert_ce_rise_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_ce_n) |-> req_ready);

endmodule

bind nand_seq_top nand_seq_chk chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .dq_oe(dq_oe),
  .rd_valid(rd_valid)
);

// File: tb/nand_seq_top_tb_top.sv
`timescale 1ns/1ps
module nand_seq_top_tb_top;

  localparam int CLK_PERIOD = 5;
  localparam int DW = 8;
  localparam int TW = 4;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [TW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [DW-1:0] req_byte = '0;
  logic          req_ready;
  logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, dq_oe, rd_valid;
  logic [DW-1:0] dq_out, rd_data;
  logic [DW-1:0] dq_in = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // per-request observations
  int i_wf, i_wr, i_lon, i_loff, i_rf, i_rr, i_rdv, n_rdv, i_done, n_ale, n_cle;
  int oe_bad, dq_bad, ce_bad;
  logic [DW-1:0] v_rd;

  always #(CLK_PERIOD/2.0) clk = ~clk;

  nand_seq_top #(.DW(DW), .TW(TW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_op(req_op),
    .req_byte(req_byte), .req_ready(req_ready), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, cycle %0d expected < %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int addr, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = TW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_defaults();
    cfg_write(0, 2); cfg_write(1, 2); cfg_write(2, 2); cfg_write(3, 2);
    cfg_write(4, 3); cfg_write(5, 1); cfg_write(6, 2); cfg_write(7, 1);
    cfg_write(8, 2); cfg_write(9, 1); cfg_write(10, 2);
  endtask

  // issue one request and watch the pins cycle by cycle (index 0 = first busy cycle)
  // mid_addr >= 0: write timing register mid_addr with mid_val during cycle 0
  task automatic run_op(input int op, input int byte_v, input int base,
                        input int mid_addr, input int mid_val);
    logic p_we, p_re, p_cle, p_ale;
    int lowcnt;
    i_wf = -1; i_wr = -1; i_lon = -1; i_loff = -1; i_rf = -1; i_rr = -1;
    i_rdv = -1; n_rdv = 0; i_done = -1; n_ale = 0; n_cle = 0;
    oe_bad = 0; dq_bad = 0; ce_bad = 0; v_rd = '0; lowcnt = 0;
    p_we = 1'b1; p_re = 1'b1; p_cle = 1'b0; p_ale = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_byte = DW'(byte_v);
    @(posedge clk);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        if (mid_addr >= 0) begin
          cfg_we = 1'b1; cfg_addr = 4'(mid_addr); cfg_wdata = TW'(mid_val);
        end
      end else begin
        cfg_we = 1'b0;
      end
      if (req_ready) begin
        i_done = k;
        break;
      end
      if (nand_ce_n) ce_bad++;
      if (op == 3) begin
        if (dq_oe) oe_bad++;
      end else begin
        if (!dq_oe) oe_bad++;
        if (dq_out != DW'(byte_v)) dq_bad++;
      end
      if (p_we && !nand_we_n) i_wf = k;
      if (!p_we && nand_we_n) i_wr = k;
      if (p_re && !nand_re_n) i_rf = k;
      if (!p_re && nand_re_n) i_rr = k;
      if (!p_cle && nand_cle) i_lon = k;
      if (p_cle && !nand_cle) i_loff = k;
      if (!p_ale && nand_ale) i_lon = k;
      if (p_ale && !nand_ale) i_loff = k;
      if (nand_ale) n_ale++;
      if (nand_cle) n_cle++;
      if (rd_valid) begin n_rdv++; i_rdv = k; v_rd = rd_data; end
      if (!nand_re_n) begin lowcnt++; dq_in = DW'(base + lowcnt); end
      p_we = nand_we_n; p_re = nand_re_n; p_cle = nand_cle; p_ale = nand_ale;
    end
    // latch may drop exactly as the request ends
    if ((p_cle && !nand_cle) || (p_ale && !nand_ale)) i_loff = i_done;
    if (rd_valid) begin n_rdv++; i_rdv = i_done; v_rd = rd_data; end
    @(negedge clk);
    if (rd_valid) n_rdv++;
  endtask

  task automatic t_reset();
    check("R1 reset ce_n", int'(nand_ce_n), 1);
    check("R1 reset strobes/latches/oe", int'({nand_we_n, nand_re_n, nand_cle, nand_ale, dq_oe}), 5'b11000);
    check("R1 reset ready", int'(req_ready), 1);
  endtask

  task automatic t_cmd_default();
    // S = max(3,2,2,2)=3, E = 3+max(1,1,2)=5
    run_op(0, 8'h70, 0, -1, 0);
    check("R2 cmd we fall", i_wf, 1);
    check("R2 cmd we rise", i_wr, 3);
    check("R2 cmd ce low while busy", ce_bad, 0);
    check("R3 cmd cle on", i_lon, 1);
    check("R3 cmd cle off", i_loff, 4);
    check("R3 cmd ale stays low", n_ale, 0);
    check("R4 cmd oe", oe_bad, 0);
    check("R4 cmd dq byte", dq_bad, 0);
    check("R5 cmd length", i_done, 5);
    check("R8 ce high when idle", int'(nand_ce_n), 1);
    check("R1 idle quiet", int'({nand_we_n, nand_re_n, nand_cle, nand_ale, dq_oe}), 5'b11000);
  endtask

  task automatic t_addr_custom();
    // alsu=5 alh=3: S=5, ale 0..7, E=5+max(1,3,2)=8
    cfg_write(8, 5); cfg_write(9, 3);
    run_op(1, 8'h3c, 0, -1, 0);
    check("R3 addr ale on", i_lon, 0);
    check("R3 addr ale off", i_loff, 8);
    check("R3 addr cle stays low", n_cle, 0);
    check("R2 addr we fall", i_wf, 3);
    check("R2 addr we rise", i_wr, 5);
    check("R5 addr length", i_done, 8);
    check("R4 addr dq byte", dq_bad, 0);
    cfg_defaults();
  endtask

  task automatic t_data_write();
    // dsu=6: S=6, no latch, E=6+max(1,0,2)=8
    cfg_write(10, 6);
    run_op(2, 8'ha5, 0, -1, 0);
    check("R3 data no cle", n_cle, 0);
    check("R3 data no ale", n_ale, 0);
    check("R2 data we fall", i_wf, 4);
    check("R2 data we rise", i_wr, 6);
    check("R5 data length", i_done, 8);
    check("R4 data oe", oe_bad, 0);
    cfg_defaults();
  endtask

  task automatic t_read(input int rp, input int reh, input int ceh, input int base);
    int r_pt, tail;
    cfg_write(2, rp); cfg_write(3, reh); cfg_write(5, ceh);
    r_pt = 1 + rp;
    tail = (reh > ceh) ? reh : ceh;
    run_op(3, 0, base, -1, 0);
    check("R6 read re fall", i_rf, 1);
    check("R6 read re rise", i_rr, r_pt);
    check("R6 read oe off", oe_bad, 0);
    check("R6 read length", i_done, r_pt + tail);
    check("R7 read data", int'(v_rd), (base + rp) % 256);
    check("R7 rd_valid index", i_rdv, r_pt);
    check("R7 rd_valid single", n_rdv, 1);
    cfg_defaults();
  endtask

  task automatic t_back_to_back();
    int ce_high, done2, lat_a;
    ce_high = 0; done2 = -1; lat_a = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_byte = 8'h00;
    @(posedge clk);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k == 0) begin req_op = 2'd1; req_byte = 8'h12; end
      if (k == 6) req_valid = 1'b0;
      if (k > 6 && req_ready && done2 < 0) done2 = k;
      if (done2 < 0 && nand_ce_n) ce_high++;
      if (k > 6 && nand_ale) lat_a++;
      if (done2 >= 0) break;
    end
    // first ends at 5, second starts at 6 and lasts 5 -> done at 11
    check("R8 ce held across seam", ce_high, 0);
    check("R8 second done", done2, 11);
    check("R8 ce rises after second", int'(nand_ce_n), 1);
    check("R3 second ale cycles", lat_a, 3);
  endtask

  task automatic t_cfg_midop();
    // wp written to 5 during a busy request: this one keeps 2, next uses 5
    run_op(0, 8'h11, 0, 0, 5);
    check("R10 busy request unchanged", i_wr - i_wf, 2);
    run_op(0, 8'h11, 0, -1, 0);
    check("R10 next request uses new wp", i_wr - i_wf, 5);
    check("R9 wider wp sets S", i_wr, 5);
    cfg_write(0, 0);
    run_op(0, 8'h11, 0, -1, 0);
    check("R9 zero wp acts as one", i_wr - i_wf, 1);
    cfg_defaults();
  endtask

  task automatic t_busy_ignores();
    // valid during busy must not start a second request
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2; req_byte = 8'h44;
    @(posedge clk);
    @(negedge clk);
    check("R5 ready low while busy", int'(req_ready), 0);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    check("R5 returns to idle", int'(req_ready), 1);
    check("R8 ce released", int'(nand_ce_n), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_cmd_default();
    t_addr_custom();
    t_data_write();
    t_read(2, 2, 1, 8'h20);
    t_read(4, 1, 3, 8'h80);
    t_back_to_back();
    t_cfg_midop();
    t_busy_ignores();
    summary();
    $finish;
  end

endmodule